// File: doc/BRIEF.md
# Double-Buffered Bulk IN Endpoint Buffer

This block holds the outgoing data of one bulk IN endpoint of a full-speed USB function. A local processor loads packet bytes through a 16-bit load pointer, written as a high and a low byte, and a data port. Each store lands at the pointer address, and the pointer then steps forward by one. This lets the processor stream a packet in without handling any address arithmetic. Two packet buffers of `MAX_PKT` bytes sit side by side in the pointer's address space: buffer 0 at offsets 0..MAX_PKT-1 and buffer 1 at MAX_PKT..2*MAX_PKT-1.

The processor hands a loaded buffer to the bus side by writing its byte count. The two buffers are used strictly in turn. When the host's IN token arrives, the block either streams the bytes of the buffer that is next in line to the serializer or asks for a NAK handshake. A NAK is asked for only when no buffer is armed. After the host acknowledges, the buffer returns to the processor and the data toggle flips. A missing acknowledgement leaves the packet armed so that it is repeated. While one packet is on the bus or waiting for its handshake, the processor is free to fill and arm the other buffer.

Top module: `bulk_in_pingpong`

## Requirements
- R1: A write with `cpu_sel`=0 sets bits 15:8 of the load pointer, and a write with `cpu_sel`=1 sets bits 7:0.
- R2: A write with `cpu_sel`=2 stores `cpu_wdata` at the pointer address, and the pointer then increments by one, wrapping at 16 bits. Address b*MAX_PKT+k is byte k of buffer b. A write to an address at or above 2*MAX_PKT stores nothing into either buffer.
- R3: A write with `cpu_sel`=3 and a value from 0 to MAX_PKT arms buffer `cpu_next` with that byte count, sets its bit in `cpu_busy`, and toggles `cpu_next`. A count above MAX_PKT, or a target buffer that is already busy, leaves every state unchanged.
- R4: A data write whose address falls in a busy buffer stores nothing. The pointer still advances.
- R5: An IN token in the idle state with no armed buffer gives a one-cycle `tx_nak` pulse in the next cycle and no `tx_start`. `tx_nak` never asserts while any buffer is armed.
- R6: An IN token in the idle state with the active buffer armed gives a one-cycle `tx_start` in the next cycle. In that cycle and the following count-1 cycles, `tx_valid` is high and `tx_data` carries the buffer bytes in address order. `tx_last` marks the final byte. A count of 0 gives `tx_start` with no `tx_valid`.
- R7: `tx_ack` while waiting for a handshake clears the buffer's `cpu_busy` bit, moves the active buffer to the other one, and flips `tx_pid` (0 = DATA0, 1 = DATA1).
- R8: `tx_timeout` while waiting leaves the buffer armed. The next IN token resends the same bytes with the same `tx_pid`.
- R9: An IN token while a packet is being sent or awaits its handshake gives neither `tx_nak` nor `tx_start`. `tx_ack` outside the waiting state changes nothing.
- R10: After reset, `cpu_busy`=0, `cpu_next`=0, `tx_pid`=0 (DATA0), and `tx_nak`, `tx_start` and `tx_valid` are low.
- R11: While one buffer is armed or awaiting its handshake, the other buffer can be loaded and armed. It is then sent at the IN token that follows the first packet's acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Processor register write strobe |
| cpu_sel | input | 2 | Register select: 0 pointer high, 1 pointer low, 2 data, 3 arm count |
| cpu_wdata | input | 8 | Processor write data |
| cpu_busy | output | 2 | Per-buffer armed flag |
| cpu_next | output | 1 | Buffer that the next arm write will target |
| in_tok | input | 1 | IN token received for this endpoint (one-cycle pulse) |
| tx_ack | input | 1 | Host ACK received (one-cycle pulse) |
| tx_timeout | input | 1 | Handshake timeout (one-cycle pulse) |
| tx_nak | output | 1 | Answer the token with NAK |
| tx_start | output | 1 | Start of a data packet |
| tx_valid | output | 1 | `tx_data` holds a packet byte |
| tx_data | output | 8 | Packet byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_pid | output | 1 | Data toggle of the packet: 0 DATA0, 1 DATA1 |

## Verification
The bench builds the block with its default values: MAX_PKT=64 and a 16-bit pointer. This brings a full 64-byte packet, the count 65 that must be refused, and the out-of-range addresses 0x0080 and 0x0100 within reach. Either of those addresses would alias byte 0 of buffer 0 if the range check were missing. A stimulus table walks packets of 0, 1, 3, 17 and 64 bytes through both buffers with an alternating data toggle. Directed tests then cover retry after timeout, tokens during a transfer, blocked and out-of-range stores, a refused arm, and a second buffer filled while the first awaits its handshake.

// File: rtl/bulk_in_pingpong.sv
`timescale 1ns/1ps
module bulk_in_pingpong #(
  parameter int MAX_PKT = 64,
  parameter int PTR_W   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_wr,
  input  logic [1:0] cpu_sel,
  input  logic [7:0] cpu_wdata,
  output logic [1:0] cpu_busy,
  output logic       cpu_next,
  input  logic       in_tok,
  input  logic       tx_ack,
  input  logic       tx_timeout,
  output logic       tx_nak,
  output logic       tx_start,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_last,
  output logic       tx_pid
);
  localparam int OFF_W = $clog2(MAX_PKT);
  localparam int LEN_W = $clog2(MAX_PKT + 1);
  localparam int DEPTH = 2 * MAX_PKT;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} st_t;

  st_t              st;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       mem [DEPTH];
  logic [LEN_W-1:0] len [2];
  logic [OFF_W-1:0] idx;
  logic             act;

  wire             wr_hi    = cpu_wr && cpu_sel == 2'd0;
  wire             wr_lo    = cpu_wr && cpu_sel == 2'd1;
  wire             wr_dat   = cpu_wr && cpu_sel == 2'd2;
  wire             wr_cnt   = cpu_wr && cpu_sel == 2'd3;
  wire [OFF_W:0]   waddr    = ptr[OFF_W:0];
  wire             in_range = ptr[PTR_W-1:OFF_W+1] == '0;
  wire             store    = wr_dat && in_range && !cpu_busy[waddr[OFF_W]];
  wire             arm      = wr_cnt && !cpu_busy[cpu_next] && int'(cpu_wdata) <= MAX_PKT;
  wire             take     = in_tok && st == S_IDLE;
  wire             rel      = st == S_WAIT && tx_ack;
  wire [1:0]       set_m    = arm ? (cpu_next ? 2'b10 : 2'b01) : 2'b00;
  wire [1:0]       clr_m    = rel ? (act ? 2'b10 : 2'b01) : 2'b00;

  assign tx_valid = st == S_SEND;
  assign tx_data  = mem[{act, idx}];
  assign tx_last  = tx_valid && (LEN_W'(idx) + LEN_W'(1) == len[act]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      ptr <= '0;
    else if (wr_hi)
      ptr[PTR_W-1:8] <= cpu_wdata[PTR_W-9:0];
    else if (wr_lo)
      ptr[7:0] <= cpu_wdata;
    else if (wr_dat)
      ptr <= ptr + 1'b1;

  always_ff @(posedge clk)
    if (store) mem[waddr] <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      len[0] <= '0;
      len[1] <= '0;
    end else if (arm) begin
      len[cpu_next] <= LEN_W'(cpu_wdata);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpu_busy <= '0;
      cpu_next <= 1'b0;
    end else begin
      cpu_busy <= (cpu_busy | set_m) & ~clr_m;
      if (arm) cpu_next <= ~cpu_next;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_nak   <= 1'b0;
      tx_start <= 1'b0;
    end else begin
      tx_nak   <= take && !cpu_busy[act];
      tx_start <= take && cpu_busy[act];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      idx    <= '0;
      act    <= 1'b0;
      tx_pid <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (take && cpu_busy[act]) begin
            idx <= '0;
            st  <= (len[act] == '0) ? S_WAIT : S_SEND;
          end
        S_SEND: begin
          idx <= idx + 1'b1;
          if (tx_last) st <= S_WAIT;
        end
        S_WAIT:
          if (tx_ack) begin
            st     <= S_IDLE;
            act    <= ~act;
            tx_pid <= ~tx_pid;
          end else if (tx_timeout) begin
            st <= S_IDLE;
          end
        default: st <= S_IDLE;
      endcase
    end
endmodule

// File: rtl/bulk_in_pingpong_chk.sv
`timescale 1ns/1ps
module bulk_in_pingpong_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_wr,
  input logic [1:0] cpu_sel,
  input logic [1:0] cpu_busy,
  input logic       cpu_next,
  input logic       tx_ack,
  input logic       tx_nak,
  input logic       tx_start,
  input logic       tx_valid,
  input logic       tx_last,
  input logic       tx_pid
);
  a_r5_nak_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_nak |-> $past(cpu_busy) == 2'b00);

  a_r5_nak_not_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_nak && tx_start));

  a_r3_arm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_busy[0]) || $rose(cpu_busy[1])) |-> $past(cpu_wr && cpu_sel == 2'd3));

  a_r3_next_moves_on_arm: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cpu_next) |-> $past(cpu_wr && cpu_sel == 2'd3));

  a_r7_release_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cpu_busy[0]) || $fell(cpu_busy[1])) |-> $past(tx_ack));

  a_r7_pid_flips_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_pid) |-> $past(tx_ack));

  a_r6_last_within_packet: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  a_r6_send_from_armed: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> cpu_busy != 2'b00);
endmodule

bind bulk_in_pingpong bulk_in_pingpong_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
  .cpu_busy(cpu_busy), .cpu_next(cpu_next), .tx_ack(tx_ack),
  .tx_nak(tx_nak), .tx_start(tx_start), .tx_valid(tx_valid),
  .tx_last(tx_last), .tx_pid(tx_pid)
);

// File: tb/bulk_in_pingpong_test.sv
`timescale 1ns/1ps
module bulk_in_pingpong_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [1:0] cpu_sel = '0;
  logic [7:0] cpu_wdata = '0;
  logic in_tok = 1'b0, tx_ack = 1'b0, tx_timeout = 1'b0;
  logic [1:0] cpu_busy;
  logic cpu_next, tx_nak, tx_start, tx_valid, tx_last, tx_pid;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  bulk_in_pingpong uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_busy(cpu_busy), .cpu_next(cpu_next), .in_tok(in_tok), .tx_ack(tx_ack),
    .tx_timeout(tx_timeout), .tx_nak(tx_nak), .tx_start(tx_start), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_pid(tx_pid)
  );

  // {count, first byte}; bytes of a packet are first, first+1, ...
  localparam logic [15:0] VEC [0:4] = '{
    {8'd3, 8'h10}, {8'd64, 8'hA0}, {8'd0, 8'h00}, {8'd1, 8'h5C}, {8'd17, 8'h31}
  };

  int n_chk = 0, n_bad = 0;
  logic [7:0] rx [0:127];
  int rx_n, last_at;
  bit got_nak, got_start, got_pid;
  bit exp_pid = 1'b0, exp_next = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr(2'd0, a[15:8]);
    wr(2'd1, a[7:0]);
  endtask

  task automatic load(input int b, input int n, input logic [7:0] first);
    set_ptr(16'(b * 64));
    for (int i = 0; i < n; i++) wr(2'd2, 8'(first + i));
  endtask

  task automatic token();
    @(negedge clk); in_tok = 1'b1;
    @(negedge clk); in_tok = 1'b0;
    got_nak = tx_nak; got_start = tx_start; got_pid = tx_pid;
    rx_n = 0; last_at = -1;
    while (tx_valid && rx_n < 100) begin
      rx[rx_n] = tx_data;
      if (tx_last) last_at = rx_n;
      rx_n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse_ack();
    @(negedge clk); tx_ack = 1'b1;
    @(negedge clk); tx_ack = 1'b0;
  endtask

  task automatic pulse_timeout();
    @(negedge clk); tx_timeout = 1'b1;
    @(negedge clk); tx_timeout = 1'b0;
  endtask

  task automatic check_pkt(input string req, input int n, input logic [7:0] first, input bit pid);
    int bad;
    bad = 0;
    chk(got_start && !got_nak, req, int'(got_start), 1);
    chk(rx_n == n, req, rx_n, n);
    for (int i = 0; i < rx_n && i < n; i++) if (rx[i] != 8'(first + i)) bad++;
    chk(bad == 0, req, bad, 0);
    chk(last_at == n - 1, req, last_at, n - 1);
    chk(got_pid == pid, req, int'(got_pid), int'(pid));
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(cpu_busy == 2'b00, "R10 busy", int'(cpu_busy), 0);
    chk(cpu_next == 1'b0, "R10 next", int'(cpu_next), 0);
    chk(tx_pid == 1'b0 && !tx_valid && !tx_nak && !tx_start, "R10 outputs",
        int'({tx_pid, tx_valid, tx_nak, tx_start}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_busy == 2'b00 && !tx_valid, "R10 after release", int'(cpu_busy), 0);

    // R5 token with nothing armed
    token();
    chk(got_nak && !got_start, "R5 nak", int'({got_nak, got_start}), 2);
    @(negedge clk);
    chk(!tx_nak, "R5 nak one cycle", int'(tx_nak), 0);

    // R2 R3 R6 R7 stimulus table
    foreach (VEC[v]) begin
      int cnt, b;
      logic [7:0] first;
      cnt = int'(VEC[v][15:8]); first = VEC[v][7:0]; b = int'(exp_next);
      load(b, cnt, first);
      wr(2'd3, 8'(cnt));
      exp_next = ~exp_next;
      chk(cpu_busy[b] == 1'b1, "R3 arm sets busy", int'(cpu_busy), 1 << b);
      chk(cpu_next == exp_next, "R3 next toggles", int'(cpu_next), int'(exp_next));
      token();
      check_pkt("R6 R2 table packet", cnt, first, exp_pid);
      pulse_ack();
      exp_pid = ~exp_pid;
      chk(cpu_busy == 2'b00, "R7 ack releases", int'(cpu_busy), 0);
      chk(tx_pid == exp_pid, "R7 pid flips", int'(tx_pid), int'(exp_pid));
    end

    // R8 timeout resend; R9 token while waiting
    load(int'(exp_next), 4, 8'h70);
    wr(2'd3, 8'd4);
    exp_next = ~exp_next;
    token();
    check_pkt("R8 first send", 4, 8'h70, exp_pid);
    token();
    chk(!got_nak && !got_start && rx_n == 0, "R9 token while waiting",
        int'({got_nak, got_start}), 0);
    pulse_timeout();
    chk(cpu_busy != 2'b00, "R8 stays armed", int'(cpu_busy), 1);
    token();
    check_pkt("R8 resend", 4, 8'h70, exp_pid);
    pulse_ack();
    exp_pid = ~exp_pid;
    chk(cpu_busy == 2'b00 && cpu_next == exp_next, "R8 release after resend",
        int'(cpu_busy), 0);

    // R1 R2 range and high byte, R4 blocked store, R11 fill other, R3 refused arm
    set_ptr(16'h0000); wr(2'd2, 8'h11);
    set_ptr(16'h0100); wr(2'd2, 8'hEE);
    set_ptr(16'h0080); wr(2'd2, 8'hEE);
    wr(2'd3, 8'd1);
    exp_next = ~exp_next;
    set_ptr(16'h0000); wr(2'd2, 8'h99);
    load(1, 2, 8'h21);
    wr(2'd3, 8'd2);
    exp_next = ~exp_next;
    chk(cpu_busy == 2'b11, "R11 both armed", int'(cpu_busy), 3);
    wr(2'd3, 8'd3);
    chk(cpu_busy == 2'b11 && cpu_next == exp_next, "R3 arm of busy ignored",
        int'(cpu_next), int'(exp_next));
    pulse_ack();
    chk(cpu_busy == 2'b11 && tx_pid == exp_pid, "R9 ack in idle ignored",
        int'({cpu_busy, tx_pid}), int'({2'b11, exp_pid}));
    token();
    check_pkt("R1 R2 R4 out-of-range and blocked stores", 1, 8'h11, exp_pid);
    pulse_ack();
    exp_pid = ~exp_pid;
    chk(cpu_busy == 2'b10, "R11 second still armed", int'(cpu_busy), 2);
    token();
    check_pkt("R11 second buffer", 2, 8'h21, exp_pid);
    pulse_ack();
    exp_pid = ~exp_pid;
    wr(2'd3, 8'd65);
    chk(cpu_busy == 2'b00 && cpu_next == exp_next, "R3 count over max ignored",
        int'({cpu_busy, cpu_next}), int'({2'b00, exp_next}));
    token();
    chk(got_nak && !got_start, "R5 nak when drained", int'({got_nak, got_start}), 2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule